// File: doc/BRIEF.md
# Configuration Transaction Engine

This block gives software a small command interface for reaching configuration functions on a main board or a plug-in daughter board. It has three 32-bit registers on a simple register bus: a data register, a command register and a status register. Software places operands in the data register, then writes the command word. The command word holds a routing target (controller index, site, position and device), a function code, a direction flag and a launch bit.

A write with the launch bit set starts exactly one transaction. The launch bit is not stored. In the next cycle an internal responder carries out the command. A read places its result in the data register. A write takes its operand from the data register. The status register then reports that the transaction is done, and whether it failed.

The responder handles these commands:
- Voltage-sensor reads. Daughter-board values come from a parameter-sized table that is loaded through dedicated configuration inputs. The main board has one fixed sensor.
- Power-off and restart requests. Each is issued as a one-cycle pulse.
- Two display-related selections. These are accepted but have no effect.

Top module: `cfgx_top`

## Requirements
- R1: Writing the command register (byte offset 0xA4) stores the word with bit 31 and bits 19:18 forced to zero. Reading it back returns the stored word, so the launch bit always reads as zero after the write.
- R2: A command write with bit 31 set starts one transaction. Status and data are updated at the end of the following cycle. Status then reads 1 on success or 3 on failure (bit 0 = done, bit 1 = error).
- R3: A transaction fails when any of these holds: the controller index (bits 29:26) is not 0, the position (bits 15:12) is not 0, or the site (bits 17:16) is neither 0 (main) nor 1 (daughter).
- R4: A read (bit 30 = 0) with function 2 (bits 25:20), site 1 and device (bits 11:0) below the sensor count loads table entry [device] into the data register. A device at or above the count fails and leaves the data register unchanged.
- R5: A read with function 2, site 0 and device 0 loads 3300000 (0x325AA0) into the data register. Any other read fails.
- R6: A write (bit 30 = 1) to site 0, device 0 with function 8 raises the power-off output, and with function 9 raises the restart output. The output is high for one cycle, the cycle after the launching write. No other command raises either output, and the two are never high together.
- R7: A write to site 0, device 0 with function 7 or 11 succeeds with no pulse and no change to the data register. Any other write command fails.
- R8: Writing the status register (offset 0xA8) stores bits 1:0 of the written word, so software can clear done and error.
- R9: The data register (offset 0xA0) is read/write. A read of any other address returns 0.
- R10: In the cycle a transaction completes, its status update wins over a bus write to the status register. A successful read's result likewise wins over a bus write to the data register. A failed read or a write command lets the bus write to the data register take effect.
- R11: A command write with bit 31 clear starts nothing: no pulse, and status is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, valid during a read) |
| tbl_we | input | 1 | Sensor table entry write enable |
| tbl_idx | input | IDX_W | Sensor table entry index |
| tbl_din | input | 32 | Sensor table entry value |
| shutdown_req | output | 1 | One-cycle power-off request |
| reboot_req | output | 1 | One-cycle restart request |

## Verification
The assertions assume:
- The bus holds a single access per cycle and drives no X on the strobes.
- The sensor table is not rewritten in the cycle a daughter-board read executes.
- Reset is held for at least one clock edge.

The stimulus keeps to these assumptions in the following ways:
- Inputs change only on the falling clock edge.
- Table loading happens before any transaction.
- Collisions are created on purpose only in the one place the design defines them: bus writes to data or status in the completion cycle.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int WORD_W = 32;

  // stored command bits: launch (31) and the two reserved bits (19:18) dropped
  localparam logic [WORD_W-1:0] CMD_KEEP_MASK = 32'h7FF3_FFFF;

  // fixed main-board sensor reading, microvolts
  localparam logic [WORD_W-1:0] MAIN_SENSOR_UV = 32'd3300000;

  typedef struct packed {
    logic        launch;   // 31
    logic        is_write; // 30
    logic [3:0]  ctl;      // 29:26
    logic [5:0]  fn;       // 25:20
    logic [1:0]  rsvd;     // 19:18
    logic [1:0]  site;     // 17:16
    logic [3:0]  pos;      // 15:12
    logic [11:0] dev;      // 11:0
  } cmd_t;

  localparam logic [5:0] FN_SENSOR  = 6'd2;
  localparam logic [5:0] FN_VIDSEL  = 6'd7;
  localparam logic [5:0] FN_PWROFF  = 6'd8;
  localparam logic [5:0] FN_RESTART = 6'd9;
  localparam logic [5:0] FN_DISPSEL = 6'd11;

  localparam logic [1:0] SITE_MAIN     = 2'd0;
  localparam logic [1:0] SITE_DAUGHTER = 2'd1;

  function automatic logic route_ok(cmd_t c);
    return (c.ctl == 4'd0) && (c.pos == 4'd0) &&
           ((c.site == SITE_MAIN) || (c.site == SITE_DAUGHTER));
  endfunction

  function automatic logic main_dev0(cmd_t c);
    return (c.site == SITE_MAIN) && (c.dev == 12'd0);
  endfunction

  function automatic logic [1:0] status_code(logic failed);
    return {failed, 1'b1};
  endfunction

  function automatic cmd_t cmd_from_word(logic [WORD_W-1:0] w);
    return cmd_t'(w & CMD_KEEP_MASK);
  endfunction

endpackage

// File: rtl/cfgx_vtable.sv
module cfgx_vtable #(
  parameter int NSENS = 4,
  parameter int IDX_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IDX_W-1:0]             idx,
  input  logic [cfgx_pkg::WORD_W-1:0]  din,
  output logic [NSENS*cfgx_pkg::WORD_W-1:0] flat
);
  import cfgx_pkg::*;

  for (genvar g = 0; g < NSENS; g++) begin : g_entry
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              q <= '0;
      else if (we && (idx == IDX_W'(g)))       q <= din;
    end
    assign flat[g*WORD_W +: WORD_W] = q;
  end

endmodule

// File: rtl/cfgx_resp.sv
module cfgx_resp #(
  parameter int NSENS = 4
) (
  input  cfgx_pkg::cmd_t                    cmd,
  input  logic [NSENS*cfgx_pkg::WORD_W-1:0] table_flat,
  output logic                              ok,
  output logic [cfgx_pkg::WORD_W-1:0]       rd_val,
  output logic                              pwroff_hit,
  output logic                              restart_hit
);
  import cfgx_pkg::*;

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{cmd.launch, cmd.rsvd};

  logic dev_in_table;
  assign dev_in_table = int'(cmd.dev) < NSENS;

  always_comb begin
    ok          = 1'b0;
    rd_val      = '0;
    pwroff_hit  = 1'b0;
    restart_hit = 1'b0;
    if (route_ok(cmd)) begin
      if (cmd.is_write) begin
        if (main_dev0(cmd)) begin
          unique case (cmd.fn)
            FN_VIDSEL, FN_DISPSEL: ok = 1'b1;
            FN_PWROFF:  begin ok = 1'b1; pwroff_hit  = 1'b1; end
            FN_RESTART: begin ok = 1'b1; restart_hit = 1'b1; end
            default: ;
          endcase
        end
      end else if (cmd.fn == FN_SENSOR) begin
        if (cmd.site == SITE_DAUGHTER && dev_in_table) begin
          ok = 1'b1;
          for (int i = 0; i < NSENS; i++)
            if (cmd.dev == 12'(i)) rd_val = table_flat[i*WORD_W +: WORD_W];
        end else if (main_dev0(cmd)) begin
          ok     = 1'b1;
          rd_val = MAIN_SENSOR_UV;
        end
      end
    end
  end

endmodule

// File: rtl/cfgx_top.sv
module cfgx_top #(
  parameter int ADDR_W   = 8,
  parameter int NSENS    = 4,
  parameter int OFS_DATA = 'hA0,
  parameter int OFS_CMD  = 'hA4,
  parameter int OFS_STAT = 'hA8,
  localparam int IDX_W   = (NSENS > 1) ? $clog2(NSENS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [31:0]       tbl_din,
  output logic              shutdown_req,
  output logic              reboot_req
);
  import cfgx_pkg::*;

  // named bus events
  logic hit_data, hit_cmd, hit_stat, launch;
  assign hit_data = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
  assign hit_cmd  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
  assign hit_stat = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign launch   = hit_cmd && bus_wdata[31];

  logic [WORD_W-1:0] data_q;
  cmd_t              cmd_q;
  logic [1:0]        stat_q;
  logic              go_q;

  logic [NSENS*WORD_W-1:0] table_flat;
  logic                    xact_ok, pwroff_hit, restart_hit;
  logic [WORD_W-1:0]       xact_val;

  cfgx_vtable #(.NSENS(NSENS), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .idx(tbl_idx), .din(tbl_din),
    .flat(table_flat)
  );

  cfgx_resp #(.NSENS(NSENS)) u_resp (
    .cmd(cmd_q), .table_flat(table_flat), .ok(xact_ok), .rd_val(xact_val),
    .pwroff_hit(pwroff_hit), .restart_hit(restart_hit)
  );

  // internal events brought out for the checker
  logic xact_fire, xact_err, xact_load;
  assign xact_fire = go_q;
  assign xact_err  = go_q && !xact_ok;
  assign xact_load = go_q && xact_ok && !cmd_q.is_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      cmd_q  <= '0;
      data_q <= '0;
      stat_q <= '0;
    end else begin
      go_q <= launch;
      if (hit_cmd) cmd_q <= cmd_from_word(bus_wdata);
      if (xact_load)     data_q <= xact_val;
      else if (hit_data) data_q <= bus_wdata;
      if (xact_fire)     stat_q <= status_code(xact_err);
      else if (hit_stat) stat_q <= bus_wdata[1:0];
    end
  end

  assign shutdown_req = xact_fire && pwroff_hit;
  assign reboot_req   = xact_fire && restart_hit;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == ADDR_W'(OFS_DATA))      bus_rdata = data_q;
      else if (bus_addr == ADDR_W'(OFS_CMD))  bus_rdata = cmd_q;
      else if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = {30'd0, stat_q};
    end
  end

endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hit_cmd,
  input logic              hit_stat,
  input logic              launch,
  input logic [31:0]       wdata,
  input logic              go,
  input logic [31:0]       cmd_word,
  input logic [1:0]        stat,
  input logic              shut,
  input logic              rebt,
  input logic [ADDR_W-1:0] addr
);

  logic unused_addr;
  assign unused_addr = ^addr;

  // R1
  cmd_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cmd |=> (cmd_word == ($past(wdata) & 32'h7FF3_FFFF)));

  // R2
  done_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> ##1 stat[0]);

  // R3
  bad_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && ((cmd_word[29:26] != 4'd0) || (cmd_word[15:12] != 4'd0) || cmd_word[17]))
      |=> (stat == 2'b11));

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shut, rebt}));

  // R6
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shut || rebt) |-> $past(launch));

  // R8
  stat_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_stat && !go) |=> (stat == $past(wdata[1:0])));

  // R11
  no_launch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cmd && !wdata[31]) |=> (!go && !shut && !rebt));

endmodule

bind cfgx_top cfgx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_cmd(hit_cmd), .hit_stat(hit_stat),
  .launch(launch), .wdata(bus_wdata), .go(xact_fire), .cmd_word(cmd_q),
  .stat(stat_q), .shut(shutdown_req), .rebt(reboot_req), .addr(bus_addr)
);

// File: tb/cfgx_top_test.sv
module cfgx_top_test;

  localparam int PERIOD = 10;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, bwr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_idx = '0;
  logic [31:0] tbl_din = '0;
  logic        shut, rebt;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  cfgx_top uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(bwr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_din(tbl_din), .shutdown_req(shut), .reboot_req(rebt)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_data, m_cmd;
  logic [1:0]  m_stat;
  bit          m_go, m_shut, m_rebt;
  logic [31:0] m_tab [NS];

  task automatic model_exec(input logic [31:0] c, output bit ok,
                            output logic [31:0] v, output bit sd, output bit rb);
    int ctl, fn, site, pos, dev;
    ctl = int'(c >> 26) & 15; fn = int'(c >> 20) & 63; site = int'(c >> 16) & 3;
    pos = int'(c >> 12) & 15; dev = int'(c) & 4095;
    ok = 0; v = 0; sd = 0; rb = 0;
    if (ctl == 0 && pos == 0 && site < 2) begin
      if (c[30]) begin
        if (site == 0 && dev == 0) begin
          if (fn == 7 || fn == 11) ok = 1;
          if (fn == 8) begin ok = 1; sd = 1; end
          if (fn == 9) begin ok = 1; rb = 1; end
        end
      end else if (fn == 2) begin
        if (site == 1 && dev < NS) begin ok = 1; v = m_tab[dev]; end
        else if (site == 0 && dev == 0) begin ok = 1; v = 32'd3300000; end
      end
    end
  endtask

  always @(posedge clk) begin
    bit ok, sd, rb;
    logic [31:0] v, nd, nc;
    logic [1:0] ns;
    bit ng;
    if (!rst_n) begin
      m_data = 0; m_cmd = 0; m_stat = 0; m_go = 0; m_shut = 0; m_rebt = 0;
      for (int i = 0; i < NS; i++) m_tab[i] = 0;
    end else begin
      nd = m_data; nc = m_cmd; ns = m_stat; ng = 0;
      if (sel && bwr) begin
        if (addr == 8'hA0) nd = wdata;
        if (addr == 8'hA8) ns = wdata[1:0];
        if (addr == 8'hA4) begin
          nc = wdata; nc[31] = 1'b0; nc[19:18] = 2'b00; ng = wdata[31];
        end
      end
      if (m_go) begin
        model_exec(m_cmd, ok, v, sd, rb);
        ns = ok ? 2'd1 : 2'd3;
        if (ok && !m_cmd[30]) nd = v;
      end
      if (tbl_we) m_tab[tbl_idx] = tbl_din;
      m_data = nd; m_cmd = nc; m_stat = ns; m_go = ng;
      m_shut = 0; m_rebt = 0;
      if (m_go) begin
        model_exec(m_cmd, ok, v, sd, rb);
        m_shut = sd; m_rebt = rb;
      end
    end
  end

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'hA0:   return m_data;
      8'hA4:   return m_cmd;
      8'hA8:   return {30'd0, m_stat};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R6 model shutdown", {31'd0, shut}, {31'd0, m_shut});
      chk("R6 model reboot", {31'd0, rebt}, {31'd0, m_rebt});
      if (sel && !bwr) chk("R9 model readback", rdata, model_read(addr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    sel = 1; bwr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; bwr = 0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    sel = 1; bwr = 0; addr = a;
    #1;
    chk(tag, rdata, exp);
    @(negedge clk);
    sel = 0;
  endtask

  // launch, capture pulses in the execute cycle, wait until status is visible
  task automatic xact(input logic [31:0] c, output bit sd, output bit rb);
    do_wr(8'hA4, c);
    #1; sd = shut; rb = rebt;
    @(negedge clk);
  endtask

  task automatic load_tbl(input int i, input logic [31:0] d);
    tbl_we = 1; tbl_idx = 2'(i); tbl_din = d;
    @(negedge clk);
    tbl_we = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit sd, rb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    do_rd(8'hA0, 32'h0, "R9 reset data");
    do_rd(8'hA4, 32'h0, "R1 reset command");
    do_rd(8'hA8, 32'h0, "R8 reset status");

    // R1 / R11: no launch
    do_wr(8'hA4, 32'h7FFF_FFFF);
    #1; chk("R11 no pulse", {30'd0, shut, rebt}, 32'd0);
    @(negedge clk);
    do_rd(8'hA4, 32'h7FF3_FFFF, "R1 masked store");
    do_rd(8'hA8, 32'h0, "R11 status unchanged");

    for (int i = 0; i < NS; i++) load_tbl(i, 32'h0010_0000 + 32'(i) * 32'h1111);

    // R4 table read
    xact(32'h8021_0002, sd, rb);
    do_rd(8'hA8, 32'd1, "R2 done");
    do_rd(8'hA0, 32'h0010_2222, "R4 table entry");
    xact(32'h8021_0004, sd, rb);
    do_rd(8'hA8, 32'd3, "R4 out of range error");
    do_rd(8'hA0, 32'h0010_2222, "R4 data kept");

    // R5 main sensor
    xact(32'h8020_0000, sd, rb);
    do_rd(8'hA0, 32'h0032_5AA0, "R5 main sensor");
    do_rd(8'hA8, 32'd1, "R5 status");

    // R3 bad routes
    xact(32'h8420_0000, sd, rb);
    do_rd(8'hA8, 32'd3, "R3 controller");
    xact(32'h8020_1000, sd, rb);
    do_rd(8'hA8, 32'd3, "R3 position");
    xact(32'h8022_0000, sd, rb);
    do_rd(8'hA8, 32'd3, "R3 site");
    do_rd(8'hA4, 32'h0022_0000, "R1 launch reads zero");

    // R8 status store
    do_wr(8'hA8, 32'hFFFF_FFFF);
    do_rd(8'hA8, 32'd3, "R8 two bits");
    do_wr(8'hA8, 32'h0000_0002);
    do_rd(8'hA8, 32'd2, "R8 error only");
    do_wr(8'hA8, 32'h0);
    do_rd(8'hA8, 32'd0, "R8 clear");

    // R6 pulses
    xact(32'hC080_0000, sd, rb);
    chk("R6 power-off pulse", {30'd0, sd, rb}, 32'd2);
    #1; chk("R6 pulse one cycle", {30'd0, shut, rebt}, 32'd0);
    do_rd(8'hA8, 32'd1, "R6 status");
    xact(32'hC090_0000, sd, rb);
    chk("R6 restart pulse", {30'd0, sd, rb}, 32'd1);
    xact(32'hC081_0000, sd, rb);
    chk("R6 daughter no pulse", {30'd0, sd, rb}, 32'd0);
    do_rd(8'hA8, 32'd3, "R7 bad write error");
    xact(32'hC090_0001, sd, rb);
    chk("R6 device1 no pulse", {30'd0, sd, rb}, 32'd0);

    // R7 accepted no-ops
    do_wr(8'hA0, 32'h1234_5678);
    xact(32'hC070_0000, sd, rb);
    chk("R7 fn7 no pulse", {30'd0, sd, rb}, 32'd0);
    do_rd(8'hA8, 32'd1, "R7 fn7 ok");
    xact(32'hC0B0_0000, sd, rb);
    do_rd(8'hA8, 32'd1, "R7 fn11 ok");
    do_rd(8'hA0, 32'h1234_5678, "R7 data unchanged");

    // R10 collisions
    do_wr(8'hA4, 32'h8020_0000);
    do_wr(8'hA0, 32'hDEAD_BEEF);
    do_rd(8'hA0, 32'h0032_5AA0, "R10 read result wins");
    do_wr(8'hA4, 32'h8020_0000);
    do_wr(8'hA8, 32'h0);
    do_rd(8'hA8, 32'd1, "R10 status wins");
    do_wr(8'hA4, 32'h8420_0000);
    do_wr(8'hA0, 32'hCAFE_F00D);
    do_rd(8'hA0, 32'hCAFE_F00D, "R10 failed read lets bus write");

    // R11 write command without launch
    do_wr(8'hA8, 32'h0);
    do_wr(8'hA4, 32'h4080_0000);
    #1; chk("R11 no pulse on store", {30'd0, shut, rebt}, 32'd0);
    @(negedge clk);
    do_rd(8'hA8, 32'd0, "R11 status untouched");

    // R9 map
    do_wr(8'hA0, 32'hA5A5_0F0F);
    do_rd(8'hA0, 32'hA5A5_0F0F, "R9 data rw");
    do_rd(8'hAC, 32'h0, "R9 unmapped");
    do_rd(8'h00, 32'h0, "R9 unmapped low");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule